// File: doc/BRIEF.md
# Host Parallel Port with Vectored Commands

This block is a byte-wide slave port. It lets an external host processor reach a DSP core through a window of eight byte-sized registers. Through this window the host sets the handshake options, polls transfer status, sends and receives 24-bit words, and raises vectored interrupts on the core. A 24-bit word is split into high, middle and low bytes at three consecutive addresses that end at address 7. A host can therefore move a word with one 24-bit access, one 16-bit access plus one byte access, or three byte accesses. Writing the low byte completes an outgoing word, and reading the low byte consumes an incoming word.

Writing a 7-bit vector together with a pending bit raises an interrupt request to the core, carrying that vector. The pending bit stays set until the core acknowledges the request, so the host can poll it. While the stop input is high, the port is electrically silent: it ignores all host accesses, drives no host-side output and keeps every register value.

Every host access is synchronous to `clk`. The host presents the address and chip select, raises one strobe and then drops it. A write takes effect on the first clock edge of the write strobe. A read consumes data at the first clock edge after the read strobe ends.

Top module: `hpp_port`

## Requirements
- R1: After reset: control reads 0x00, status reads 0x02, the command register reads 0x00, and `tx_valid`, `irq_req`, `h_req` and `h_ack` are low while `rx_ready` is high.
- R2: Address map: 0 is control (bits 2:0 writable, upper bits read 0), 1 is status (read-only), 2 is command, 3 is a freely readable and writable 8-bit interrupt vector, 4 always reads 0, and 5, 6 and 7 are the high, middle and low data bytes.
- R3: `h_doe` is high only while `h_cs` and `h_rd` are both high and `stop_i` is low.
- R4: Writes to 5 and 6 stage the upper bytes. A write to 7 presents {high, middle, written byte} on `tx_word` with `tx_valid` high and clears status bit 1 (transmit empty). The word holds steady until `tx_ready` is seen, and then status bit 1 sets again.
- R5: While a transmit word is waiting (status bit 1 low), writes to addresses 5, 6 and 7 are ignored, including the staged upper bytes.
- R6: A core word is taken when `rx_valid` and `rx_ready` are both high, and this sets status bit 0 (receive full) and drops `rx_ready`. Bytes 5, 6 and 7 read the word. Reading 5 or 6 leaves it in place. The end of a read of 7 clears status bit 0.
- R7: With control bit 2 = 0, `h_req` = (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R8: With control bit 2 = 1, `h_req` = status bit 1 AND control bit 1, and `h_ack` = status bit 0 AND control bit 0.
- R9: A write to 2 loads the vector from bits 6:0 and the pending bit from bit 7. `irq_req` follows the pending bit and `irq_vec` follows the vector. Reading 2 returns {pending, vector}.
- R10: `irq_ack` during `irq_req` clears the pending bit. Command writes while the pending bit is set are ignored.
- R11: While `stop_i` is high, `h_doe`, `h_req` and `h_ack` are low and host writes change nothing. After `stop_i` falls, every register holds its earlier value.
- R12: With control bit 2 = 0, `h_ack` rises one clock after a selected strobe begins and falls one clock after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Core stop mode; silences the host side |
| h_cs | input | 1 | Host chip select, active high |
| h_rd | input | 1 | Host read strobe, active high |
| h_wr | input | 1 | Host write strobe, active high |
| h_addr | input | 3 | Host register address |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Read data toward the host |
| h_doe | output | 1 | Drive enable for the host data bus |
| h_req | output | 1 | Host request handshake |
| h_ack | output | 1 | Host acknowledge / receive request |
| tx_word | output | 24 | Word handed to the core |
| tx_valid | output | 1 | `tx_word` is valid |
| tx_ready | input | 1 | Core accepts `tx_word` |
| rx_word | input | 24 | Word offered by the core |
| rx_valid | input | 1 | `rx_word` is valid |
| rx_ready | output | 1 | Port can take `rx_word` |
| irq_req | output | 1 | Vectored interrupt request to the core |
| irq_vec | output | 7 | Vector carried with `irq_req` |
| irq_ack | input | 1 | Core acknowledges the interrupt |

## Verification
The assertions check on every cycle that the bus is driven only during a selected read outside stop, and that stop mode silences all handshake outputs. They also check that pending transmit words and interrupt vectors hold until the core takes them, and that each core-side handshake closes on the following cycle. Only the bench scenarios can show the register map contents, the assembly of the byte order into words, the rule that data writes are ignored while a word is waiting, the pop on the low-byte read, the two handshake modes and the preservation of state across stop.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int ADDR_W  = 3;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 24;
  localparam int VEC_W   = 7;
  localparam int CTL_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IVEC = 3'd3;
  localparam logic [ADDR_W-1:0] A_RSV  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DLO  = 3'd7;

  localparam int C_RXEN  = 0;
  localparam int C_TXEN  = 1;
  localparam int C_SPLIT = 2;

  // address of data byte idx (0 = least significant)
  function automatic logic [ADDR_W-1:0] data_addr(input int idx);
    return ADDR_W'(int'(A_DLO) - idx);
  endfunction

  function automatic logic is_data_addr(input logic [ADDR_W-1:0] a, input int nbytes);
    return int'(a) > int'(A_DLO) - nbytes;
  endfunction

  // {request, acknowledge} pin values from control, flags and strobe ack
  function automatic logic [1:0] hs_pins(input logic [CTL_W-1:0] ctl, input logic rxf,
                                         input logic txe, input logic strobe_ack);
    logic rx_r, tx_r;
    rx_r = rxf & ctl[C_RXEN];
    tx_r = txe & ctl[C_TXEN];
    if (ctl[C_SPLIT]) return {tx_r, rx_r};
    return {rx_r | tx_r, strobe_ack};
  endfunction

  function automatic logic [BYTE_W-1:0] stat_byte(input logic rxf, input logic txe);
    return {{(BYTE_W-2){1'b0}}, txe, rxf};
  endfunction
endpackage

// File: rtl/hpp_strobe.sv
module hpp_strobe
  import hpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              h_cs,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  output logic              wr_pulse,
  output logic              rd_active,
  output logic              rd_end,
  output logic [ADDR_W-1:0] rd_end_addr,
  output logic              strobe_ack
);
  logic rd_g, wr_g, rd_q, wr_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign rd_g = h_cs & h_rd & ~stop_i;
  assign wr_g = h_cs & h_wr & ~stop_i;

  assign wr_pulse    = wr_g & ~wr_q;
  assign rd_active   = rd_g;
  assign rd_end      = ~rd_g & rd_q;
  assign rd_end_addr = rd_addr_q;
  assign strobe_ack  = rd_q | wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q <= rd_g;
      wr_q <= wr_g;
      if (rd_g && !rd_q) rd_addr_q <= h_addr;
    end
  end
endmodule

// File: rtl/hpp_xfer.sv
module hpp_xfer
  import hpp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_end,
  input  logic [ADDR_W-1:0] rd_end_addr,
  output logic [W-1:0]      tx_word,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [W-1:0]      rx_word,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [W-1:0]      rx_hold,
  output logic              rx_full,
  output logic              tx_empty
);
  localparam int NB = W / BYTE_W;

  logic [BYTE_W-1:0] stage_q [1:NB-1];
  logic [W-1:0]      tx_q, rx_q;
  logic              tx_v, rx_f;
  logic              data_wr, pop;

  assign data_wr  = wr_pulse & ~tx_v & is_data_addr(wr_addr, NB);
  assign pop      = rd_end & (rd_end_addr == A_DLO) & rx_f;
  assign tx_word  = tx_q;
  assign tx_valid = tx_v;
  assign tx_empty = ~tx_v;
  assign rx_ready = ~rx_f;
  assign rx_full  = rx_f;
  assign rx_hold  = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i < NB; i++) stage_q[i] <= '0;
      tx_q <= '0;
      tx_v <= 1'b0;
    end else begin
      if (tx_v && tx_ready) tx_v <= 1'b0;
      if (data_wr) begin
        for (int i = 1; i < NB; i++)
          if (wr_addr == data_addr(i)) stage_q[i] <= wr_data;
        if (wr_addr == A_DLO) begin
          for (int i = 1; i < NB; i++) tx_q[BYTE_W*i +: BYTE_W] <= stage_q[i];
          tx_q[BYTE_W-1:0] <= wr_data;
          tx_v <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
      rx_f <= 1'b0;
    end else if (rx_valid && !rx_f) begin
      rx_q <= rx_word;
      rx_f <= 1'b1;
    end else if (pop) begin
      rx_f <= 1'b0;
    end
  end
endmodule

// File: rtl/hpp_cmd.sv
module hpp_cmd
  import hpp_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VW-1:0]     irq_vec
);
  logic          pend_q;
  logic [VW-1:0] vec_q;
  logic          cmd_wr;

  assign cmd_wr  = wr_pulse & (wr_addr == A_CMD) & ~pend_q;
  assign irq_req = pend_q;
  assign irq_vec = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else if (cmd_wr) begin
      vec_q  <= wr_data[VW-1:0];
      pend_q <= wr_data[BYTE_W-1];
    end else if (pend_q && irq_ack) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hpp_port.sv
module hpp_port
  import hpp_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int VW = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              h_cs,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [BYTE_W-1:0] h_din,
  output logic [BYTE_W-1:0] h_dout,
  output logic              h_doe,
  output logic              h_req,
  output logic              h_ack,
  output logic [W-1:0]      tx_word,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [W-1:0]      rx_word,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq_req,
  output logic [VW-1:0]     irq_vec,
  input  logic              irq_ack
);
  logic              wr_pulse, rd_active, rd_end, strobe_ack;
  logic [ADDR_W-1:0] rd_end_addr;
  logic [W-1:0]      rx_hold;
  logic              rx_full, tx_empty;
  logic [CTL_W-1:0]  ctl_q;
  logic [BYTE_W-1:0] ivec_q, rd_mux;
  logic [1:0]        hs;

  hpp_strobe u_strobe (
    .clk, .rst_n, .stop_i, .h_cs, .h_rd, .h_wr, .h_addr,
    .wr_pulse, .rd_active, .rd_end, .rd_end_addr, .strobe_ack
  );

  hpp_xfer #(.W(W)) u_xfer (
    .clk, .rst_n, .wr_pulse, .wr_addr(h_addr), .wr_data(h_din),
    .rd_end, .rd_end_addr, .tx_word, .tx_valid, .tx_ready,
    .rx_word, .rx_valid, .rx_ready, .rx_hold, .rx_full, .tx_empty
  );

  hpp_cmd #(.VW(VW)) u_cmd (
    .clk, .rst_n, .wr_pulse, .wr_addr(h_addr), .wr_data(h_din),
    .irq_ack, .irq_req, .irq_vec
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ivec_q <= '0;
    end else if (wr_pulse) begin
      if (h_addr == A_CTL)  ctl_q  <= h_din[CTL_W-1:0];
      if (h_addr == A_IVEC) ivec_q <= h_din;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_data_addr(h_addr, W / BYTE_W))
      rd_mux = BYTE_W'(rx_hold >> (BYTE_W * (int'(A_DLO) - int'(h_addr))));
    else begin
      case (h_addr)
        A_CTL:   rd_mux = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
        A_STAT:  rd_mux = stat_byte(rx_full, tx_empty);
        A_CMD:   rd_mux = {irq_req, irq_vec};
        A_IVEC:  rd_mux = ivec_q;
        default: rd_mux = '0;
      endcase
    end
  end

  assign hs     = hs_pins(ctl_q, rx_full, tx_empty, strobe_ack);
  assign h_doe  = rd_active;
  assign h_dout = rd_active ? rd_mux : '0;
  assign h_req  = hs[1] & ~stop_i;
  assign h_ack  = hs[0] & ~stop_i;
endmodule

// File: rtl/hpp_port_chk.sv
module hpp_port_chk #(
  parameter int W  = 24,
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_i,
  input logic          h_cs,
  input logic          h_rd,
  input logic          h_doe,
  input logic          h_req,
  input logic          h_ack,
  input logic [W-1:0]  tx_word,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          irq_req,
  input logic          irq_ack,
  input logic [VW-1:0] irq_vec
);
  a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    h_doe |-> (h_cs && h_rd && !stop_i));

  a_r11_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> (!h_doe && !h_req && !h_ack));

  a_r4_tx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));

  a_r4_tx_handoff_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  a_r6_rx_take_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  a_r10_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
endmodule

bind hpp_port hpp_port_chk #(.W(W), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .h_cs(h_cs), .h_rd(h_rd),
  .h_doe(h_doe), .h_req(h_req), .h_ack(h_ack), .tx_word(tx_word),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
);

// File: tb/hpp_port_test.sv
`timescale 1ns/1ps
module hpp_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_i = 1'b0;
  logic h_cs = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_din = '0;
  logic [7:0] h_dout;
  logic h_doe, h_req, h_ack;
  logic [23:0] tx_word;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [23:0] rx_word = '0;
  logic rx_valid = 1'b0;
  logic rx_ready, irq_req;
  logic [6:0] irq_vec;
  logic irq_ack = 1'b0;

  int total = 0;
  int bad = 0;
  logic last_doe;

  always #2.5 clk = ~clk;

  hpp_port uut (
    .clk, .rst_n, .stop_i, .h_cs, .h_rd, .h_wr, .h_addr, .h_din, .h_dout,
    .h_doe, .h_req, .h_ack, .tx_word, .tx_valid, .tx_ready, .rx_word,
    .rx_valid, .rx_ready, .irq_req, .irq_vec, .irq_ack
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_addr = a; h_din = d; h_wr = 1'b1;
    #1 last_doe = h_doe;
    @(negedge clk);
    h_wr = 1'b0; h_cs = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_addr = a; h_rd = 1'b1;
    #1 d = h_dout; last_doe = h_doe;
    @(negedge clk);
    h_rd = 1'b0; h_cs = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    host_rd(a, d);
    chk(tag, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic core_push(input logic [23:0] w);
    @(negedge clk);
    rx_word = w; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic core_take();
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 h_req", h_req, 0);
    chk("R1 h_ack", h_ack, 0);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R3 idle doe", h_doe, 0);
    rd_chk("R1 control", 3'd0, 8'h00);
    chk("R3 read doe", last_doe, 1);
    rd_chk("R1 status", 3'd1, 8'h02);
    rd_chk("R1 command", 3'd2, 8'h00);
  endtask

  task automatic t_regs();
    host_wr(3'd0, 8'hFF);
    chk("R3 write doe", last_doe, 0);
    rd_chk("R2 control mask", 3'd0, 8'h07);
    host_wr(3'd3, 8'hA5);
    rd_chk("R2 ivec", 3'd3, 8'hA5);
    host_wr(3'd4, 8'h5A);
    rd_chk("R2 reserved", 3'd4, 8'h00);
    host_wr(3'd1, 8'hFF);
    rd_chk("R2 status ro", 3'd1, 8'h02);
    host_wr(3'd0, 8'h00);
  endtask

  task automatic t_tx();
    host_wr(3'd5, 8'h12);
    host_wr(3'd6, 8'h34);
    chk("R4 no early valid", tx_valid, 0);
    host_wr(3'd7, 8'h56);
    chk("R4 tx_valid", tx_valid, 1);
    chk("R4 tx_word", tx_word, 24'h123456);
    rd_chk("R4 status busy", 3'd1, 8'h00);
    host_wr(3'd5, 8'hFF);
    host_wr(3'd7, 8'h99);
    chk("R5 word kept", tx_word, 24'h123456);
    idle(3);
    chk("R4 held", tx_valid, 1);
    core_take();
    chk("R4 taken", tx_valid, 0);
    rd_chk("R4 status empty", 3'd1, 8'h02);
    host_wr(3'd7, 8'h01);
    chk("R5 staging kept", tx_word, 24'h123401);
    core_take();
  endtask

  task automatic t_rx();
    @(negedge clk);
    rx_word = 24'hABCDEF; rx_valid = 1'b1;
    @(negedge clk);
    rx_word = 24'h111111;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R6 rx_ready low", rx_ready, 0);
    rd_chk("R6 status full", 3'd1, 8'h03);
    rd_chk("R6 high", 3'd5, 8'hAB);
    rd_chk("R6 mid", 3'd6, 8'hCD);
    idle(1);
    chk("R6 no pop on mid", rx_ready, 0);
    rd_chk("R6 low", 3'd7, 8'hEF);
    idle(1);
    chk("R6 popped", rx_ready, 1);
    rd_chk("R6 status empty", 3'd1, 8'h02);
  endtask

  task automatic t_req();
    logic [7:0] d;
    host_wr(3'd0, 8'h01); idle(1);
    chk("R7 rx en, empty", h_req, 0);
    host_wr(3'd0, 8'h02); idle(1);
    chk("R7 tx en, tx empty", h_req, 1);
    host_wr(3'd0, 8'h01);
    core_push(24'h000102); idle(1);
    chk("R7 rx en, full", h_req, 1);
    host_wr(3'd0, 8'h07); idle(1);
    chk("R8 split req", h_req, 1);
    chk("R8 split ack", h_ack, 1);
    host_wr(3'd0, 8'h06); idle(1);
    chk("R8 tx only req", h_req, 1);
    chk("R8 tx only ack", h_ack, 0);
    host_wr(3'd0, 8'h05); idle(1);
    chk("R8 rx only req", h_req, 0);
    chk("R8 rx only ack", h_ack, 1);
    host_rd(3'd7, d); idle(1);
    chk("R8 ack after pop", h_ack, 0);
    host_wr(3'd0, 8'h00); idle(1);
  endtask

  task automatic t_ack();
    @(negedge clk);
    h_cs = 1'b1; h_addr = 3'd1; h_rd = 1'b1;
    #1 chk("R12 ack not yet", h_ack, 0);
    @(negedge clk);
    chk("R12 ack up", h_ack, 1);
    h_rd = 1'b0; h_cs = 1'b0;
    #1 chk("R12 ack lingers", h_ack, 1);
    @(negedge clk);
    chk("R12 ack down", h_ack, 0);
  endtask

  task automatic t_cmd();
    host_wr(3'd2, 8'hAA);
    chk("R9 irq_req", irq_req, 1);
    chk("R9 irq_vec", irq_vec, 7'h2A);
    rd_chk("R9 pending read", 3'd2, 8'hAA);
    host_wr(3'd2, 8'h85);
    chk("R10 vec kept", irq_vec, 7'h2A);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 cleared", irq_req, 0);
    rd_chk("R10 read after ack", 3'd2, 8'h2A);
    host_wr(3'd2, 8'h11);
    chk("R9 no request", irq_req, 0);
    rd_chk("R9 vector only", 3'd2, 8'h11);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    host_wr(3'd0, 8'h02); idle(1);
    chk("R11 req before stop", h_req, 1);
    @(negedge clk); stop_i = 1'b1;
    #1 chk("R11 req silent", h_req, 0);
    host_rd(3'd1, d);
    chk("R11 no drive", last_doe, 0);
    chk("R11 ack silent", h_ack, 0);
    host_wr(3'd3, 8'h3C);
    host_wr(3'd0, 8'h00);
    host_wr(3'd2, 8'h81);
    chk("R11 cmd ignored", irq_req, 0);
    @(negedge clk); stop_i = 1'b0;
    idle(1);
    chk("R11 req restored", h_req, 1);
    rd_chk("R11 ivec kept", 3'd3, 8'hA5);
    rd_chk("R11 cmd kept", 3'd2, 8'h11);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL all: watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx();
    t_rx();
    t_req();
    t_ack();
    t_cmd();
    t_stop();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule